// File: doc/BRIEF.md
# Completion Interrupt Coalescer

This block decides when a host should be told that queued work has finished. A queue tracker supplies the number of descriptors that have completed but not yet been handled by software. The block compares that number against a programmable count threshold. An optional timeout makes sure that a small batch of completions, which never reaches the threshold, still gets reported after a bounded number of clock cycles.

A notification is delivered as a message-signalled interrupt rather than as a wire. The block issues a single write of a programmed 32-bit data word to a programmed 48-bit address. That write is presented on a valid/ready request handshake. Software sets up the threshold, the timer, the message address and the message data through a simple register write port.

After a notification the block stays quiet until the pending count rises again, so a standing backlog does not flood the host with repeated messages.

Top module: `irq_coalescer`

## Requirements
- R1: While reset is high and in the first cycle after it, `msg_valid` is low.
- R2: When the pending count is nonzero and at or above the count threshold, and the block is armed, `msg_valid` rises one clock edge later. `msg_addr` then equals {high register bits [15:0], low register} and `msg_data` equals the data register.
- R3: With the timer disabled, a pending count below the threshold never produces a message.
- R4: With the timer enabled, a nonzero pending count below the threshold produces a message once the cycle counter, started when the armed block first sees a nonzero count, reaches the timeout value.
- R5: A pending count of zero never produces a message, whatever the threshold or the timeout.
- R6: After a message fires, the block is disarmed and the timer cleared. A new message needs the pending count to rise above its value of the previous cycle. A steady or falling count sends nothing.
- R7: A raised request keeps `msg_addr` and `msg_data` unchanged until `msg_ready` is seen. Rewriting the configuration meanwhile does not alter it. Only one request is outstanding at a time.
- R8: Register decoding uses these offsets: message data word at 0x014, address low 32 bits at 0x050, address high at 0x054 (bits [15:0] kept, the rest dropped). Writes to any other offset have no effect.
- R9: The control word at 0x018 holds the count threshold in bits [14:0] and the timer enable in bit 18. Other bits of it are ignored. The timeout value lives in bits [12:0] of the word at 0x810.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| pend_cnt | input | 15 | Completed-but-unhandled descriptor count from the queue tracker |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 12 | Register byte offset |
| cfg_wdata | input | 32 | Register write data |
| msg_valid | output | 1 | Message write request pending |
| msg_ready | input | 1 | Message write accepted by the fabric |
| msg_addr | output | 48 | Message target address |
| msg_data | output | 32 | Message data word |

## Verification
The count is held below the threshold, held exactly at it, and stepped down and then up. This separates threshold triggering from re-arming, and shows that a standing backlog stays quiet. Timeout runs use both a long and a short timeout value, written with stray high bits, which shows how wide the field is and where the timer starts. A zero count under a zero threshold and a zero timeout shows that an empty queue never signals. A stalled `msg_ready` combined with a data rewrite shows that the request holds its contents. Configuration writes with stray bits in ignored positions, and a write to an unmapped offset, show how fields are decoded. A cycle-accurate model compares every output on every clock.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
    localparam int CNT_W   = 15;
    localparam int TMO_W   = 13;
    localparam int ADDR_W  = 48;
    localparam int DATA_W  = 32;
    localparam int OFF_W   = 12;
    localparam int HI_W    = ADDR_W - 32;
    localparam int EN_BIT  = 18;

    localparam logic [OFF_W-1:0] OFF_CTRL = 12'h018;
    localparam logic [OFF_W-1:0] OFF_TMO  = 12'h810;
    localparam logic [OFF_W-1:0] OFF_ALO  = 12'h050;
    localparam logic [OFF_W-1:0] OFF_AHI  = 12'h054;
    localparam logic [OFF_W-1:0] OFF_DATA = 12'h014;

    typedef enum logic [2:0] {
        SEL_NONE, SEL_CTRL, SEL_TMO, SEL_ALO, SEL_AHI, SEL_DATA
    } irqc_sel_e;

    typedef struct packed {
        logic [CNT_W-1:0]  thr;
        logic              tmr_en;
        logic [TMO_W-1:0]  tmo;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } irqc_cfg_t;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } irqc_msg_t;

    function automatic irqc_sel_e irqc_decode(input logic [OFF_W-1:0] off);
        irqc_sel_e s;
        case (off)
            OFF_CTRL: s = SEL_CTRL;
            OFF_TMO:  s = SEL_TMO;
            OFF_ALO:  s = SEL_ALO;
            OFF_AHI:  s = SEL_AHI;
            OFF_DATA: s = SEL_DATA;
            default:  s = SEL_NONE;
        endcase
        return s;
    endfunction
endpackage

// File: rtl/irqc_cfg_regs.sv
module irqc_cfg_regs
    import irqc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [OFF_W-1:0]  addr,
    input  logic [DATA_W-1:0] wdata,
    output irqc_cfg_t         cfg
);
    irqc_sel_e sel;

    always_comb sel = irqc_decode(addr);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg <= '0;
        end else if (we) begin
            case (sel)
                SEL_CTRL: begin
                    cfg.thr    <= wdata[CNT_W-1:0];
                    cfg.tmr_en <= wdata[EN_BIT];
                end
                SEL_TMO:  cfg.tmo               <= wdata[TMO_W-1:0];
                SEL_ALO:  cfg.addr[31:0]        <= wdata;
                SEL_AHI:  cfg.addr[ADDR_W-1:32] <= wdata[HI_W-1:0];
                SEL_DATA: cfg.data              <= wdata;
                default:  ;
            endcase
        end
    end
endmodule

// File: rtl/irqc_trigger.sv
module irqc_trigger
    import irqc_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [CNT_W-1:0] pend_cnt,
    input  logic [CNT_W-1:0] thr,
    input  logic             tmr_en,
    input  logic [TMO_W-1:0] tmo,
    input  logic             busy,
    output logic             fire,
    output logic             armed
);
    logic [CNT_W-1:0] prev_cnt;
    logic [TMO_W-1:0] ticks;
    logic             nonzero;
    logic             rising;
    logic             cnt_hit;
    logic             tmo_hit;
    logic             run;

    always_comb begin
        nonzero = (pend_cnt != '0);
        rising  = (pend_cnt > prev_cnt);
        cnt_hit = (pend_cnt >= thr);
        tmo_hit = tmr_en && (ticks >= tmo);
        fire    = armed && nonzero && !busy && (cnt_hit || tmo_hit);
        run     = armed && nonzero && !fire;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_cnt <= '0;
            ticks    <= '0;
            armed    <= 1'b1;
        end else begin
            prev_cnt <= pend_cnt;
            if (!run)
                ticks <= '0;
            else if (ticks != {TMO_W{1'b1}})
                ticks <= ticks + 1'b1;
            if (fire)
                armed <= 1'b0;
            else if (rising)
                armed <= 1'b1;
        end
    end
endmodule

// File: rtl/irqc_msg_port.sv
module irqc_msg_port
    import irqc_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      fire,
    input  irqc_msg_t msg_in,
    input  logic      ready,
    output logic      valid,
    output irqc_msg_t msg_out
);
    always_ff @(posedge clk) begin
        if (rst) begin
            valid   <= 1'b0;
            msg_out <= '0;
        end else if (fire) begin
            valid   <= 1'b1;
            msg_out <= msg_in;
        end else if (valid && ready) begin
            valid   <= 1'b0;
        end
    end
endmodule

// File: rtl/irq_coalescer.sv
module irq_coalescer
    import irqc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [CNT_W-1:0]  pend_cnt,
    input  logic              cfg_we,
    input  logic [OFF_W-1:0]  cfg_addr,
    input  logic [DATA_W-1:0] cfg_wdata,
    output logic              msg_valid,
    input  logic              msg_ready,
    output logic [ADDR_W-1:0] msg_addr,
    output logic [DATA_W-1:0] msg_data
);
    irqc_cfg_t        cfg;
    irqc_msg_t        staged;
    irqc_msg_t        held;
    logic             fire;
    logic             armed;
    logic [CNT_W-1:0] cfg_thr;
    logic             cfg_tmr_en;

    assign cfg_thr    = cfg.thr;
    assign cfg_tmr_en = cfg.tmr_en;
    assign staged     = '{addr: cfg.addr, data: cfg.data};

    irqc_cfg_regs u_regs (
        .clk   (clk),
        .rst   (rst),
        .we    (cfg_we),
        .addr  (cfg_addr),
        .wdata (cfg_wdata),
        .cfg   (cfg)
    );

    irqc_trigger u_trig (
        .clk      (clk),
        .rst      (rst),
        .pend_cnt (pend_cnt),
        .thr      (cfg.thr),
        .tmr_en   (cfg.tmr_en),
        .tmo      (cfg.tmo),
        .busy     (msg_valid),
        .fire     (fire),
        .armed    (armed)
    );

    irqc_msg_port u_port (
        .clk     (clk),
        .rst     (rst),
        .fire    (fire),
        .msg_in  (staged),
        .ready   (msg_ready),
        .valid   (msg_valid),
        .msg_out (held)
    );

    assign msg_addr = held.addr;
    assign msg_data = held.data;
endmodule

// File: rtl/irqc_checker.sv
module irqc_checker
    import irqc_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic [CNT_W-1:0]  pend_cnt,
    input logic              msg_valid,
    input logic              msg_ready,
    input logic [ADDR_W-1:0] msg_addr,
    input logic [DATA_W-1:0] msg_data,
    input logic              fire,
    input logic [CNT_W-1:0]  cfg_thr,
    input logic              cfg_tmr_en
);
    a_r1_quiet_after_reset: assert property (@(posedge clk)
        $past(rst) |-> !msg_valid);

    a_r7_hold: assert property (@(posedge clk) disable iff (rst)
        (msg_valid && !msg_ready) |=> (msg_valid && $stable(msg_addr) && $stable(msg_data)));

    a_r7_single: assert property (@(posedge clk) disable iff (rst)
        msg_valid |-> !fire);

    a_r5_no_zero: assert property (@(posedge clk) disable iff (rst)
        $rose(msg_valid) |-> ($past(pend_cnt) != '0));

    a_r3_below_quiet: assert property (@(posedge clk) disable iff (rst)
        ($rose(msg_valid) && !$past(cfg_tmr_en)) |-> ($past(pend_cnt) >= $past(cfg_thr)));
endmodule

bind irq_coalescer irqc_checker u_chk (
    .clk        (clk),
    .rst        (rst),
    .pend_cnt   (pend_cnt),
    .msg_valid  (msg_valid),
    .msg_ready  (msg_ready),
    .msg_addr   (msg_addr),
    .msg_data   (msg_data),
    .fire       (fire),
    .cfg_thr    (cfg_thr),
    .cfg_tmr_en (cfg_tmr_en)
);

// File: tb/irq_coalescer_tb.sv
module irq_coalescer_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [14:0] pend = '0;
    logic        we = 1'b0;
    logic [11:0] waddr = '0;
    logic [31:0] wdata = '0;
    logic        ready = 1'b1;
    logic        msg_valid;
    logic [47:0] msg_addr;
    logic [31:0] msg_data;

    int    errors = 0;
    int    checks = 0;
    int    msgs = 0;
    int    exp_msgs = 0;
    string phase = "R1";
    logic [47:0] last_addr = '0;
    logic [31:0] last_data = '0;

    // behavioural reference state
    longint m_thr, m_en, m_tmo, m_tick, m_prev, m_armed, m_busy;
    longint m_cfg_addr, m_cfg_data, m_addr, m_data;

    irq_coalescer u_dut (
        .clk(clk), .rst(rst), .pend_cnt(pend), .cfg_we(we), .cfg_addr(waddr),
        .cfg_wdata(wdata), .msg_valid(msg_valid), .msg_ready(ready),
        .msg_addr(msg_addr), .msg_data(msg_data)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input bit ok, input string tag, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    always @(posedge clk) begin
        longint p;
        bit hit, acc;
        if (rst) begin
            m_thr = 0; m_en = 0; m_tmo = 0; m_tick = 0; m_prev = 0;
            m_armed = 1; m_busy = 0; m_cfg_addr = 0; m_cfg_data = 0;
            m_addr = 0; m_data = 0;
        end else begin
            p   = longint'(pend);
            hit = (m_armed != 0) && (p != 0) && (m_busy == 0) &&
                  (p >= m_thr || (m_en != 0 && m_tick >= m_tmo));
            acc = (m_busy != 0) && ready;
            if (m_armed != 0 && p != 0 && !hit)
                m_tick = (m_tick < 8191) ? m_tick + 1 : m_tick;
            else
                m_tick = 0;
            if (hit) m_armed = 0;
            else if (p > m_prev) m_armed = 1;
            if (hit) begin
                m_busy = 1; m_addr = m_cfg_addr; m_data = m_cfg_data;
            end else if (acc) begin
                m_busy = 0;
            end
            m_prev = p;
            if (we) begin
                case (waddr)
                    12'h018: begin m_thr = longint'(wdata[14:0]); m_en = longint'(wdata[18]); end
                    12'h810: m_tmo = longint'(wdata[12:0]);
                    12'h050: m_cfg_addr = (m_cfg_addr & 48'hFFFF_0000_0000) | longint'(wdata);
                    12'h054: m_cfg_addr = (m_cfg_addr & 48'h0000_FFFF_FFFF) | (longint'(wdata[15:0]) << 32);
                    12'h014: m_cfg_data = longint'(wdata);
                    default: ;
                endcase
            end
        end
    end

    always @(negedge clk) begin
        if (!rst) begin
            check(msg_valid == (m_busy != 0), phase, "msg_valid vs model", msg_valid, m_busy);
            if (msg_valid && m_busy != 0) begin
                check(msg_addr == m_addr[47:0], phase, "msg_addr vs model", msg_addr, m_addr);
                check(msg_data == m_data[31:0], phase, "msg_data vs model", msg_data, m_data);
            end
            if (msg_valid && ready) begin
                msgs++;
                last_addr = msg_addr;
                last_data = msg_data;
            end
        end
    end

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(posedge clk); #1;
        we = 1'b1; waddr = a; wdata = d;
        @(posedge clk); #1;
        we = 1'b0;
    endtask

    task automatic set_pend(input int v);
        @(posedge clk); #1;
        pend = 15'(v);
    endtask

    task automatic expect_msgs(input string tag, input int add);
        exp_msgs += add;
        check(msgs == exp_msgs, tag, "message count", msgs, exp_msgs);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        step(3);
        check(msg_valid == 1'b0, "R1", "valid in reset", msg_valid, 0);
        rst = 1'b0;
        step(1);
        check(msg_valid == 1'b0, "R1", "valid after reset", msg_valid, 0);

        phase = "R8";
        wr(12'h050, 32'h89AB_CDEF);
        wr(12'h054, 32'hFFFF_1234);
        wr(12'h014, 32'hCAFE_0001);
        wr(12'h018, 32'd5);
        wr(12'h810, 32'd20);
        wr(12'h01C, 32'hFFFF_FFFF);

        phase = "R3";
        set_pend(3); step(50);
        expect_msgs("R3", 0);

        phase = "R2";
        set_pend(5); step(5);
        expect_msgs("R2", 1);
        check(last_addr == 48'h1234_89AB_CDEF, "R8", "48-bit address", last_addr, 48'h1234_89AB_CDEF);
        check(last_data == 32'hCAFE_0001, "R2", "data word", last_data, 32'hCAFE_0001);

        phase = "R6";
        step(30);
        expect_msgs("R6", 0);
        set_pend(4); step(20);
        expect_msgs("R6", 0);
        set_pend(6); step(5);
        expect_msgs("R6", 1);

        phase = "R7";
        ready = 1'b0;
        set_pend(7); step(3);
        check(msg_valid == 1'b1, "R7", "request raised", msg_valid, 1);
        wr(12'h014, 32'h1234_5678);
        step(5);
        check(msg_valid == 1'b1, "R7", "request held", msg_valid, 1);
        check(msg_data == 32'hCAFE_0001, "R7", "held data", msg_data, 32'hCAFE_0001);
        ready = 1'b1;
        step(3);
        expect_msgs("R7", 1);
        check(msg_valid == 1'b0, "R7", "released", msg_valid, 0);

        phase = "R4";
        wr(12'h018, (32'd1 << 18) | 32'd100);
        wr(12'h810, 32'd20);
        set_pend(0); step(3);
        set_pend(2); step(15);
        expect_msgs("R4", 0);
        step(15);
        expect_msgs("R4", 1);
        check(last_data == 32'h1234_5678, "R4", "new data word", last_data, 32'h1234_5678);

        phase = "R9";
        wr(12'h810, 32'hFFFF_E005);
        set_pend(0); step(3);
        set_pend(1); step(4);
        expect_msgs("R9", 0);
        step(6);
        expect_msgs("R9", 1);
        wr(12'h018, 32'h0000_8003);
        set_pend(0); step(3);
        set_pend(2); step(30);
        expect_msgs("R9", 0);
        set_pend(3); step(4);
        expect_msgs("R9", 1);

        phase = "R5";
        wr(12'h018, 32'd1 << 18);
        wr(12'h810, 32'd0);
        set_pend(0); step(30);
        expect_msgs("R5", 0);
        set_pend(1); step(4);
        expect_msgs("R5", 1);
        step(2);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule